// File: doc/BRIEF.md
# Gated Elapsed-Time Decade Counter

This block measures for how long an external enable signal stays asserted. A one-clock-wide tick arriving at 100 Hz is the time reference, so each tick is worth one hundredth of a second. The enable input is asynchronous to the system clock and passes through a two-flop synchronizer. A tick counts only while the synchronized enable is high. Counted ticks go into a divide-by-ten prescaler. The prescaler's carry advances a chain of decimal digits, and the lowest digit shows tenths of a second.

The digits are cascaded. Each one counts 0 to 9, and on its wrap it sends a carry into the next digit. Every digit drives its own static, active-high seven-segment bus with a decimal point. The decimal point is lit only on the digit that holds whole seconds. When the whole chain rolls over from all nines to all zeros, a one-cycle flag reports the overflow. Dropping the enable freezes the reading. The reading then stays on display until the next synchronous reset.

Top module: `hold_timer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the synchronizer, the prescaler, every digit and the overflow flag. After reset every digit shows 0 and wrap_o is 0.
- R2: enable_i passes through two flip-flops. A tick present at clock edge k is counted only if enable_i was high when sampled at edge k-2.
- R3: While the synchronized enable is low, ticks are ignored and the displayed value and the prescaler hold.
- R4: The prescaler divides counted ticks by PRESCALE (default 10). The lowest digit advances once per PRESCALE counted ticks, in the same edge as the tick that completes the group.
- R5: Each digit counts 0 to 9 and then wraps to 0. The wrap carries one count into the next higher digit in the same clock edge, and a digit without an incoming carry holds.
- R6: The displayed number equals floor(counted ticks / PRESCALE) modulo 10^DIGITS. Digit 0 (tenths) is least significant.
- R7: Digit i drives seg_o[8i+7:8i] with bit order {dp,g,f,e,d,c,b,a}, a in bit 0, where 1 lights a segment. The values of bits 6..0 for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R8: The dp bit is 1 on digit DP_DIGIT (default 1, whole seconds) and 0 on every other digit, at all times.
- R9: wrap_o is high for exactly the one cycle in which the chain shows all zeros after rolling over from all nines. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | 100 Hz time-base pulse, one clock wide |
| enable_i | input | 1 | Asynchronous measure enable, active high |
| seg_o | output | 8*DIGITS | Segment buses, 8 bits per digit, digit 0 lowest |
| wrap_o | output | 1 | One-cycle rollover flag for the whole chain |

## Verification
On every cycle the assertions check the following. Reset empties the chain. A frozen enable freezes the digits. A prescaler carry never appears without a gated tick. Each digit stays within 0..9 and moves only on an incoming carry. The decimal-point pattern is fixed. The overflow flag coincides with an all-zero display and lasts one cycle. The two-edge latency of the enable synchronizer, the division ratio and the correct decimal value across long runs can only be shown by the bench scenarios. These scenarios compare the outputs with a tick-count model under random enable and tick patterns. They also cover a rollover on a narrow two-digit instance.

// File: rtl/hold_timer_pkg.sv
package hold_timer_pkg;

  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 8;

  // Active-high segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] seg_of(input logic [DIGIT_W-1:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

  // Next value of one decade stage given its incoming count
  function automatic logic [DIGIT_W-1:0] decade_next(input logic [DIGIT_W-1:0] d,
                                                     input logic step);
    if (!step) return d;
    return (d == 4'd9) ? '0 : d + 4'd1;
  endfunction

endpackage

// File: rtl/en_sync.sv
module en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic carry_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign carry_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (carry_o) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/decade_digit.sv
module decade_digit
  import hold_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               carry_i,
  output logic [DIGIT_W-1:0] value_o,
  output logic               carry_o
);
  logic [DIGIT_W-1:0] val_q;

  assign carry_o = carry_i && (val_q == 4'd9);
  assign value_o = val_q;

  always_ff @(posedge clk) begin
    if (rst) val_q <= '0;
    else     val_q <= decade_next(val_q, carry_i);
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer
  import hold_timer_pkg::*;
#(
  parameter int unsigned DIGITS      = 5,
  parameter int unsigned PRESCALE    = 10,
  parameter int unsigned DP_DIGIT    = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  input  logic                    enable_i,
  output logic [SEG_W*DIGITS-1:0] seg_o,
  output logic                    wrap_o
);
  localparam int unsigned DW = DIGIT_W * DIGITS;

  // Named internal events, visible to the bound checker
  logic              en_q;
  logic              gated_tick;
  logic              pre_carry;
  logic [DIGITS:0]   stage_carry;
  logic [DW-1:0]     digit_flat;
  logic              wrap_q;

  en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (enable_i),
    .q_o (en_q)
  );

  assign gated_tick = tick_i && en_q;

  tick_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .step_i  (gated_tick),
    .carry_o (pre_carry)
  );

  assign stage_carry[0] = pre_carry;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    decade_digit u_dig (
      .clk     (clk),
      .rst     (rst),
      .carry_i (stage_carry[i]),
      .value_o (digit_flat[DIGIT_W*i +: DIGIT_W]),
      .carry_o (stage_carry[i+1])
    );
    assign seg_o[SEG_W*i +: SEG_W] =
      {(i == DP_DIGIT) ? 1'b1 : 1'b0, seg_of(digit_flat[DIGIT_W*i +: DIGIT_W])};
  end

  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= stage_carry[DIGITS];
  end

  assign wrap_o = wrap_q;
endmodule

// File: rtl/hold_timer_chk.sv
module hold_timer_chk #(
  parameter int unsigned DIGITS   = 5,
  parameter int unsigned DP_DIGIT = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  en_q,
  input logic                  gated_tick,
  input logic                  pre_carry,
  input logic [DIGITS:0]       stage_carry,
  input logic [4*DIGITS-1:0]   digit_flat,
  input logic [8*DIGITS-1:0]   seg_o,
  input logic                  wrap_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (digit_flat == '0 && !wrap_o));

  p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(digit_flat));

  p_prescale_source_r4: assert property (@(posedge clk) disable iff (rst)
    pre_carry |-> gated_tick);

  for (genvar i = 0; i < DIGITS; i++) begin : g_d
    p_digit_range_r5: assert property (@(posedge clk) disable iff (rst)
      digit_flat[4*i +: 4] <= 4'd9);
    p_stage_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !stage_carry[i] |=> $stable(digit_flat[4*i +: 4]));
    p_dp_fixed_r8: assert property (@(posedge clk) disable iff (rst)
      seg_o[8*i+7] == (i == DP_DIGIT));
  end

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> digit_flat == '0);

  p_wrap_single_r9: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);
endmodule

bind hold_timer hold_timer_chk #(.DIGITS(DIGITS), .DP_DIGIT(DP_DIGIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_q        (en_q),
  .gated_tick  (gated_tick),
  .pre_carry   (pre_carry),
  .stage_carry (stage_carry),
  .digit_flat  (digit_flat),
  .seg_o       (seg_o),
  .wrap_o      (wrap_o)
);

// File: tb/sim_hold_timer.sv
module sim_hold_timer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, en = 1'b0;
  logic [39:0] seg0;
  logic        wrap0;
  logic [15:0] seg1;
  logic        wrap1;

  hold_timer u0 (.clk(clk), .rst(rst), .tick_i(tick), .enable_i(en),
                 .seg_o(seg0), .wrap_o(wrap0));
  hold_timer #(.DIGITS(2)) u1 (.clk(clk), .rst(rst), .tick_i(tick), .enable_i(en),
                 .seg_o(seg1), .wrap_o(wrap1));

  int n_chk = 0, n_bad = 0;
  int total = 0;
  bit s1 = 0, s2 = 0, xw = 0, wrap_seen = 0, done = 0;

  function automatic logic [7:0] enc(input int d, input int pos);
    logic [6:0] s;
    case (d)
      0: s = 7'h3F; 1: s = 7'h06; 2: s = 7'h5B; 3: s = 7'h4F; 4: s = 7'h66;
      5: s = 7'h6D; 6: s = 7'h7D; 7: s = 7'h07; 8: s = 7'h7F; default: s = 7'h6F;
    endcase
    return {pos == 1, s};
  endfunction

  function automatic logic [39:0] exp_seg(input int ticks, input int nd);
    logic [39:0] r = '0;
    int v = ticks / 10;
    for (int i = 0; i < nd; i++) begin
      r[8*i +: 8] = enc(v % 10, i);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit t, input bit e, input bit r, input string tag);
    bit pass;
    tick = t; en = e; rst = r;
    @(posedge clk);
    pass = t && s2;
    if (r) begin
      total = 0; s1 = 0; s2 = 0; xw = 0;
    end else begin
      if (pass) total++;
      xw = pass && (total % 1000 == 0);
      s2 = s1; s1 = e;
    end
    @(negedge clk);
    chk(tag, 64'(seg0), 64'(exp_seg(total, 5)));
    chk(tag, 64'(seg1), 64'(exp_seg(total, 2) & 40'hFFFF));
    chk("R9 wrap u1", 64'(wrap1), 64'(xw));
    chk("R9 wrap u0", 64'(wrap0), 64'd0);
    if (wrap1) wrap_seen = 1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 1, 1, "R1");
    chk("R1 digits zero", 64'(seg0), 64'h3F3F3FBF3F);
    // R3: ticks with enable low are ignored
    for (int i = 0; i < 6; i++) step(1, 0, 0, "R3");
    // R2: enable rises; the first two ticks fall inside the synchronizer latency
    for (int i = 0; i < 12; i++) step(1, 1, 0, "R2");
    // R7/R8: the tenths digit now shows 1 (10 counted ticks)
    chk("R7 tenths=1", 64'(seg0[7:0]), 64'h06);
    chk("R8 dp on seconds", 64'(seg0[15:8]), 64'hBF);
    chk("R8 dp off elsewhere", 64'({seg0[39], seg0[31], seg0[23], seg0[7]}), 64'd0);
    // R2: single-cycle enable pulse
    step(0, 0, 0, "R2"); step(0, 0, 0, "R2");
    step(0, 1, 0, "R2"); step(1, 0, 0, "R2"); step(1, 0, 0, "R2"); step(1, 0, 0, "R2");
    // R4: ticks every other cycle
    for (int i = 0; i < 60; i++) step(i % 2 == 0, 1, 0, "R4");
    // R6: random tick/enable with rare reset
    for (int i = 0; i < 4000; i++)
      step(1'($urandom % 2), ($urandom % 100) < 85, ($urandom % 1000) == 0, "R6");
    // R3: hold with enable dropped
    for (int i = 0; i < 30; i++) step(1, 0, 0, "R3");
    // R9: rollover of the two-digit instance after 1000 counted ticks
    step(0, 1, 1, "R1");
    for (int i = 0; i < 1010; i++) step(1, 1, 0, "R9");
    chk("R9 rollover observed", 64'(wrap_seen), 64'd1);
    // R5: long continuous run carries into every digit of u0
    for (int i = 0; i < 120000; i++) step(1, 1, 0, "R5");
    chk("R5 top digit reached", 64'(seg0[39:32]), 64'(enc((total / 100000) % 10, 4)));
    done = 1;
    summary();
  end
endmodule